// File: doc/BRIEF.md
# Three-Wire Serial Byte Master

This block moves one byte at a time over a three-wire serial link. It drives a serial clock (`sk`) and a serial data output (`so`), and it samples a serial data input (`si`). An upstream controller hands over one byte through a valid/ready handshake. The block shifts that byte out most-significant bit first while it shifts the peer's byte in. It then raises a one-cycle `done` pulse and leaves the received byte on `rx_data`. Chip select, command framing and multi-byte sequencing all stay in the upstream controller.

The serial clock runs at the system clock divided by `CLK_DIV`, which defaults to 128. The first output bit appears on `so` in the cycle after the byte is accepted. It then stays on the line for one whole serial clock period before the first rising `sk` edge, so a slow peer has settled data on its first sample. `sk` idles low. The peer samples on rising edges, and `so` moves to the next bit on falling edges.

Back-pressure works only on the input side. A byte is accepted in a cycle where both `in_valid` and `in_ready` are high, and `in_ready` is low for the whole transfer. The output side cannot stall the block. `done` is a single-cycle qualifier, and `rx_data` holds its value until the next transfer completes.

Top module: `mw_byte_master`

## Requirements
- R1: While `rst` is high at a clock edge, and in the cycle after it, the outputs are `sk`=0, `so`=0, `rx_data`=0, `busy`=0, `done`=0 and `in_ready`=1.
- R2: A byte is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `busy` is 1 and `in_ready` is 0 from the next cycle until `done` rises. At that point `busy` returns to 0 and `in_ready` returns to 1.
- R3: In the first cycle after acceptance, `so` equals bit 7 of the accepted byte.
- R4: `sk` stays low for exactly `CLK_DIV` system clock cycles after acceptance. It rises in the next cycle.
- R5: Each transfer produces exactly eight `sk` pulses. Each pulse is high for `CLK_DIV/2` cycles, and the gap between two pulses is low for `CLK_DIV/2` cycles. `sk` is low whenever `busy` is 0.
- R6: At the k-th rising `sk` edge (k = 0..7), `so` carries bit 7-k of the accepted byte. During a transfer, `so` changes only in the cycle where `sk` falls.
- R7: `si` is sampled at each rising `sk` edge. After the transfer, bit 7-k of `rx_data` holds the value sampled at rising edge k.
- R8: `done` is high for exactly one cycle. That cycle is the one right after the eighth falling `sk` edge, which is `9*CLK_DIV - CLK_DIV/2` cycles after the first cycle following acceptance. `rx_data` is valid in that cycle and holds its value until the next `done`.
- R9: If `in_valid` is raised while `busy` is 1, it has no effect. The bits sent, the byte received and the timing of the ongoing transfer stay unchanged.
- R10: `so` is 0 whenever `busy` is 0, including after the eighth falling edge.
- R11: A synchronous reset in the middle of a transfer aborts it. In the next cycle, `sk`, `so`, `busy` and `rx_data` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A byte is offered on `in_data` |
| in_ready | output | 1 | The block can accept a byte this cycle |
| in_data | input | 8 | Byte to transmit |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| rx_data | output | 8 | Byte received in the last completed transfer |
| sk | output | 1 | Serial clock, idles low |
| so | output | 1 | Serial data out |
| si | input | 1 | Serial data in |

## Verification
The checker watches several properties on every cycle:
- `sk` and `so` stay quiet while idle.
- `so` holds steady except on a falling `sk` edge.
- The most-significant bit is presented right after acceptance.
- The lead time before the first rising edge is exactly one serial period.
- Eight pulses occur before `done`, which is a single cycle that follows a falling edge.

Other behaviours need the bench's scenarios, because they depend on data values and on order. These are the bit order on `so`, the assembly of `rx_data` from `si`, the exact total length of a transfer, the ignored start request while busy, and the abort on reset in the middle of a transfer.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEAD = 2'd1,
    PH_HIGH = 2'd2,
    PH_LOW  = 2'd3
  } phase_t;
endpackage

// File: rtl/mw_phase_timer.sv
module mw_phase_timer #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic end_full,
  output logic end_half
);
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  assign end_full = (cnt_q == CW'(DIV - 1));
  assign end_half = (cnt_q == CW'(HALF - 1));
endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
  import mw_pkg::*;
#(
  parameter int NBITS = BYTE_W
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic end_full,
  input  logic end_half,
  output logic in_ready,
  output logic busy,
  output logic sk,
  output logic done,
  output logic load,
  output logic sample,
  output logic fall,
  output logic finish,
  output logic restart
);
  localparam int BW = (NBITS > 2) ? $clog2(NBITS) : 1;

  phase_t        ph_q, ph_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          sk_q, sk_d;
  logic          done_q;

  always_comb begin
    ph_d    = ph_q;
    bit_d   = bit_q;
    sk_d    = sk_q;
    load    = 1'b0;
    sample  = 1'b0;
    fall    = 1'b0;
    finish  = 1'b0;
    restart = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (in_valid) begin
          load    = 1'b1;
          restart = 1'b1;
          bit_d   = '0;
          ph_d    = PH_LEAD;
        end
      end
      PH_LEAD: begin
        if (end_full) begin
          sk_d    = 1'b1;
          sample  = 1'b1;
          restart = 1'b1;
          ph_d    = PH_HIGH;
        end
      end
      PH_HIGH: begin
        if (end_half) begin
          sk_d    = 1'b0;
          fall    = 1'b1;
          restart = 1'b1;
          if (bit_q == BW'(NBITS - 1)) begin
            finish = 1'b1;
            ph_d   = PH_IDLE;
          end else begin
            bit_d = bit_q + 1'b1;
            ph_d  = PH_LOW;
          end
        end
      end
      PH_LOW: begin
        if (end_half) begin
          sk_d    = 1'b1;
          sample  = 1'b1;
          restart = 1'b1;
          ph_d    = PH_HIGH;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      bit_q  <= '0;
      sk_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      bit_q  <= bit_d;
      sk_q   <= sk_d;
      done_q <= finish;
    end
  end

  assign in_ready = (ph_q == PH_IDLE);
  assign busy     = (ph_q != PH_IDLE);
  assign sk       = sk_q;
  assign done     = done_q;
endmodule

// File: rtl/mw_shifter.sv
module mw_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         sample,
  input  logic         fall,
  input  logic         finish,
  input  logic         si,
  output logic         so,
  output logic [W-1:0] rx_byte
);
  logic [W-1:0] sh_q;
  logic [W-1:0] rx_q;
  logic         si_q;
  logic         so_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
      rx_q <= '0;
      si_q <= 1'b0;
      so_q <= 1'b0;
    end else begin
      if (load) begin
        sh_q <= load_data;
        so_q <= load_data[W-1];
      end
      if (sample) si_q <= si;
      if (fall) begin
        sh_q <= {sh_q[W-2:0], si_q};
        if (finish) begin
          so_q <= 1'b0;
          rx_q <= {sh_q[W-2:0], si_q};
        end else begin
          so_q <= sh_q[W-2];
        end
      end
    end
  end

  assign so      = so_q;
  assign rx_byte = rx_q;
endmodule

// File: rtl/mw_byte_master.sv
module mw_byte_master
  import mw_pkg::*;
#(
  parameter int CLK_DIV = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rx_data,
  output logic              sk,
  output logic              so,
  input  logic              si
);
  logic end_full, end_half;
  logic load, sample, fall, finish, restart;

  mw_phase_timer #(.DIV(CLK_DIV)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .end_full (end_full),
    .end_half (end_half)
  );

  mw_ctrl #(.NBITS(BYTE_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .end_full (end_full),
    .end_half (end_half),
    .in_ready (in_ready),
    .busy     (busy),
    .sk       (sk),
    .done     (done),
    .load     (load),
    .sample   (sample),
    .fall     (fall),
    .finish   (finish),
    .restart  (restart)
  );

  mw_shifter #(.W(BYTE_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_data (in_data),
    .sample    (sample),
    .fall      (fall),
    .finish    (finish),
    .si        (si),
    .so        (so),
    .rx_byte   (rx_data)
  );
endmodule

// File: rtl/mw_byte_master_chk.sv
module mw_byte_master_chk #(
  parameter int DIV = 128
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic in_msb,
  input logic busy,
  input logic done,
  input logic sk,
  input logic so
);
  logic        acc;
  logic        sk_d;
  int unsigned lead_cnt;
  int unsigned rise_cnt;

  assign acc = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      sk_d     <= 1'b0;
      lead_cnt <= 0;
      rise_cnt <= 0;
    end else begin
      sk_d <= sk;
      if (acc)       lead_cnt <= 0;
      else if (busy) lead_cnt <= lead_cnt + 1;
      if (acc)             rise_cnt <= 0;
      else if (sk && !sk_d) rise_cnt <= rise_cnt + 1;
    end
  end

  p_sk_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sk);

  p_pulses_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (rise_cnt == 8));

  p_so_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (sk && $past(sk)) |-> $stable(so));

  p_so_fall_only_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !($past(sk) && !sk)) |-> $stable(so));

  p_load_msb_r3: assert property (@(posedge clk) disable iff (rst)
    acc |=> (busy && (so == $past(in_msb))));

  p_lead_r4: assert property (@(posedge clk) disable iff (rst)
    (sk && !sk_d && rise_cnt == 0) |-> (lead_cnt == DIV));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_edge_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(sk) && !sk && !busy));

  p_so_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !so);
endmodule

bind mw_byte_master mw_byte_master_chk #(.DIV(CLK_DIV)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_msb   (in_data[7]),
  .busy     (busy),
  .done     (done),
  .sk       (sk),
  .so       (so)
);

// File: tb/mw_byte_master_tb.sv
module mw_byte_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 128;
  localparam int HALF       = DIV / 2;
  localparam int NVEC       = 6;
  localparam logic [15:0] VEC [NVEC] = '{
    16'hA5_3C, 16'hFF_00, 16'h00_FF, 16'h80_01, 16'h01_80, 16'h5A_C3
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       si = 1'b0;
  logic       in_ready, busy, done, sk, so;
  logic [7:0] rx_data;

  int total = 0;
  int bad   = 0;

  logic [7:0] rx_pat = 8'h00;
  logic [7:0] obs    = 8'h00;
  int         pulses = 0;
  int         si_idx = 0;

  mw_byte_master #(.CLK_DIV(DIV)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .busy     (busy),
    .done     (done),
    .rx_data  (rx_data),
    .sk       (sk),
    .so       (so),
    .si       (si)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge sk) begin
    obs = {obs[6:0], so};
    pulses++;
  end

  always @(negedge sk) begin
    si_idx++;
    if (si_idx < 8) si = rx_pat[7 - si_idx];
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] rp, input bit poke);
    int t;
    int first;
    rx_pat = rp;
    obs    = 8'h00;
    pulses = 0;
    si_idx = 0;
    si     = rp[7];
    @(negedge clk);
    chk(in_ready && !busy, "R2 ready before start", {in_ready, busy}, 2'b10);
    in_valid = 1'b1;
    in_data  = tx;
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = ~tx;
    chk(so == tx[7] && busy && !in_ready, "R3 msb right after load",
        {so, busy, in_ready}, {tx[7], 2'b10});
    t = 0;
    first = -1;
    while (!done && t < 4 * 9 * DIV) begin
      if (sk && first < 0) first = t;
      if (poke && t == 300) begin
        chk(!in_ready, "R9 ready low while busy", in_ready, 0);
        in_valid = 1'b1;
      end
      if (poke && t == 310) in_valid = 1'b0;
      t++;
      @(negedge clk);
    end
    chk(first == DIV, "R4 lead cycles", first, DIV);
    chk(t == 9 * DIV - HALF, "R8 done timing", t, 9 * DIV - HALF);
    chk(rx_data == rp, "R7 received byte", rx_data, rp);
    chk(obs == tx, "R6 bits on so", obs, tx);
    chk(pulses == 8, "R5 pulse count", pulses, 8);
    chk(!so && !busy && in_ready, "R10 so low at end", {so, busy, in_ready}, 3'b001);
    @(negedge clk);
    chk(!done, "R8 single-cycle done", done, 0);
    chk(rx_data == rp, "R8 rx held", rx_data, rp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!sk && !so && !busy && !done && in_ready && rx_data == 8'h00,
        "R1 reset state", {sk, so, busy, done, in_ready}, 5'b00001);
    rst = 1'b0;
    @(negedge clk);
    chk(!sk && !so && !busy && !done && in_ready && rx_data == 8'h00,
        "R1 state after reset", {sk, so, busy, done, in_ready}, 5'b00001);

    for (int i = 0; i < NVEC; i++) begin
      xfer(VEC[i][15:8], VEC[i][7:0], (i == 2));
    end

    // R11: abort in the middle of a transfer
    rx_pat = 8'h00;
    si_idx = 0;
    si = 1'b1;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'hC7;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (500) @(negedge clk);
    chk(busy, "R11 busy before abort", busy, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!sk && !so && !busy && in_ready && rx_data == 8'h00,
        "R11 abort state", {sk, so, busy, in_ready, rx_data}, {4'b0001, 8'h00});

    xfer(8'h96, 8'h69, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule